// File: doc/BRIEF.md
# Run-time selectable victim picker for one cache set

This block chooses which way of a four-way cache set is to be evicted next. It follows a stream of access events for the set. Each event names a way and says whether it was a hit on a resident line or a fill of a new line. From these events it keeps two orderings of the ways: how recently each way was touched, and how recently each way was filled. When the cache controller raises a request, the block returns a victim way under the policy it selects on that request. The five policies are least recently used, most recently used, first-in-first-out, last-in-first-out and pseudo-random.

Each ordering is stored as a rank per way. Rank 0 is the newest and rank 3 is the oldest. A way that has never been filled since reset always takes priority over any policy. The random choice comes from a free-running linear-feedback shift register. Tags, data arrays and the memory side belong to the surrounding cache and are not part of this block.

Top module: `repl_policy_unit`

## Requirements
- R1: When reset is asserted, every way becomes invalid. Both the recency ranks and the fill ranks become 0,1,2,3 for ways 0,1,2,3. `victim_o` reads 0 and `victim_valid_o` reads 0.
- R2: `policy_i` is sampled only on a cycle where `req_i` is high. `victim_o` and `victim_valid_o` show the result on the following cycle. Without a request, `victim_o` holds its value and `victim_valid_o` is 0, even if `policy_i` changes.
- R3: If any way is invalid, the victim is the lowest-numbered invalid way, whatever the policy.
- R4: With policy code 0 (least recently used), the victim is the way with recency rank 3.
- R5: With policy code 1 (most recently used), the victim is the way with recency rank 0.
- R6: With policy code 2 (first-in-first-out), the victim is the way with fill rank 3. Hits do not change this choice.
- R7: With policy code 3 (last-in-first-out), the victim is the way with fill rank 0.
- R8: With policy code 4 (random), the victim is bits [1:0] of an 8-bit shift register as it stands at the request edge. The register resets to 0xA5 and steps on every clock. It shifts left, and its new bit 0 is the XOR of the old bits 7, 5, 4 and 3.
- R9: An access is an event with `acc_valid_i` high. A hit (`acc_fill_i` low) updates only the recency ranks. A fill (`acc_fill_i` high) updates both the recency ranks and the fill ranks. In each updated order, the accessed way moves to rank 0, and every way that had a smaller rank than it moves one rank older.
- R10: Policy codes 5, 6 and 7 behave like code 0.
- R11: A fill marks its way valid. Hits do not change validity.
- R12: Changing the policy between requests leaves both orders and the valid flags untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset: asserts asynchronously, deasserts synchronously |
| acc_valid_i | input | 1 | An access event is present this cycle |
| acc_fill_i | input | 1 | 1 = fill, 0 = hit |
| acc_way_i | input | 2 | Way touched by the access |
| req_i | input | 1 | Request a victim |
| policy_i | input | 3 | Policy code, sampled when a request is made |
| victim_o | output | 2 | Chosen victim way |
| victim_valid_o | output | 1 | `victim_o` was updated by the request of the previous cycle |

## Verification
The checker assumes that reset deasserts in step with the clock, so that the shift register and the rank registers leave their reset values on the same edge. It also assumes that `acc_way_i` is only used while `acc_valid_i` is high. Under those conditions it checks four things: each order stays a permutation of 0 to 3, the shift register never reaches zero, a fill always leaves its way valid, and the invalid-first rule holds. The stimulus changes inputs only on falling edges and releases reset on a falling edge. It also tracks the shift register in a model of its own, so that each random request is compared against the state present at the sampling edge.

// File: rtl/repl_pkg.sv
package repl_pkg;
  // Policy codes presented on policy_i
  typedef enum logic [2:0] {
    POL_LRU  = 3'd0,
    POL_MRU  = 3'd1,
    POL_FIFO = 3'd2,
    POL_LIFO = 3'd3,
    POL_RAND = 3'd4
  } policy_e;

  localparam int unsigned POLICY_W = 3;
endpackage

// File: rtl/repl_rank_tracker.sv
module repl_rank_tracker #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned RANK_W  = $clog2(NUM_WAYS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       upd_i,
  input  logic [WAY_W-1:0]           way_i,
  output logic [NUM_WAYS*RANK_W-1:0] rank_o
);
  logic [RANK_W-1:0] rank_q [NUM_WAYS];
  logic [RANK_W-1:0] rank_d [NUM_WAYS];
  logic [RANK_W-1:0] sel_rank;

  assign sel_rank = rank_q[way_i];

  // next-state: touched way becomes newest, younger ones age by one
  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      rank_d[w] = rank_q[w];
      if (upd_i) begin
        if (WAY_W'(w) == way_i) begin
          rank_d[w] = '0;
        end else if (rank_q[w] < sel_rank) begin
          rank_d[w] = rank_q[w] + RANK_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < NUM_WAYS; w++) rank_q[w] <= RANK_W'(w);
    end else if (upd_i) begin
      for (int w = 0; w < NUM_WAYS; w++) rank_q[w] <= rank_d[w];
    end
  end

  generate
    for (genvar g = 0; g < NUM_WAYS; g++) begin : g_pack
      assign rank_o[g*RANK_W +: RANK_W] = rank_q[g];
    end
  endgenerate
endmodule

// File: rtl/repl_lfsr.sv
module repl_lfsr #(
  parameter int unsigned     LFSR_W = 8,
  parameter logic [LFSR_W-1:0] SEED = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_d;
  logic              fb;

  // taps for x^8 + x^6 + x^5 + x^4 + 1
  assign fb      = state_q[LFSR_W-1] ^ state_q[LFSR_W-3] ^ state_q[LFSR_W-4] ^ state_q[LFSR_W-5];
  assign state_d = {state_q[LFSR_W-2:0], fb};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/repl_victim_select.sv
module repl_victim_select
  import repl_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned RANK_W  = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0]        valid_i,
  input  logic [NUM_WAYS*RANK_W-1:0] rec_rank_i,
  input  logic [NUM_WAYS*RANK_W-1:0] ins_rank_i,
  input  logic [WAY_W-1:0]           rand_way_i,
  input  logic [POLICY_W-1:0]        policy_i,
  output logic [WAY_W-1:0]           victim_o
);
  localparam logic [RANK_W-1:0] OLDEST = RANK_W'(NUM_WAYS-1);

  function automatic logic [WAY_W-1:0] way_at_rank(
    input logic [NUM_WAYS*RANK_W-1:0] ranks,
    input logic [RANK_W-1:0]          target
  );
    logic [WAY_W-1:0] hit_way;
    hit_way = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (ranks[w*RANK_W +: RANK_W] == target) hit_way = WAY_W'(w);
    end
    return hit_way;
  endfunction

  logic             any_inv;
  logic [WAY_W-1:0] first_inv;
  logic [WAY_W-1:0] policy_way;

  // lowest-numbered invalid way
  always_comb begin
    any_inv   = 1'b0;
    first_inv = '0;
    for (int w = NUM_WAYS-1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        any_inv   = 1'b1;
        first_inv = WAY_W'(w);
      end
    end
  end

  always_comb begin
    unique case (policy_i)
      POL_MRU:  policy_way = way_at_rank(rec_rank_i, '0);
      POL_FIFO: policy_way = way_at_rank(ins_rank_i, OLDEST);
      POL_LIFO: policy_way = way_at_rank(ins_rank_i, '0);
      POL_RAND: policy_way = rand_way_i;
      default:  policy_way = way_at_rank(rec_rank_i, OLDEST);
    endcase
  end

  assign victim_o = any_inv ? first_inv : policy_way;
endmodule

// File: rtl/repl_policy_unit.sv
module repl_policy_unit
  import repl_pkg::*;
#(
  parameter int unsigned       NUM_WAYS  = 4,
  parameter int unsigned       LFSR_W    = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'hA5,
  localparam int unsigned      WAY_W     = $clog2(NUM_WAYS),
  localparam int unsigned      RANK_W    = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_valid_i,
  input  logic                acc_fill_i,
  input  logic [WAY_W-1:0]    acc_way_i,
  input  logic                req_i,
  input  logic [POLICY_W-1:0] policy_i,
  output logic [WAY_W-1:0]    victim_o,
  output logic                victim_valid_o
);
  logic [NUM_WAYS*RANK_W-1:0] rec_rank;
  logic [NUM_WAYS*RANK_W-1:0] ins_rank;
  logic [LFSR_W-1:0]          lfsr_state;
  logic [WAY_W-1:0]           victim_comb;
  logic                       fill_evt;
  logic [NUM_WAYS-1:0]        valid_q, valid_d;
  logic [WAY_W-1:0]           victim_q;
  logic                       vvalid_q;

  assign fill_evt = acc_valid_i & acc_fill_i;

  repl_rank_tracker #(.NUM_WAYS(NUM_WAYS)) u_recency (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (acc_valid_i),
    .way_i  (acc_way_i),
    .rank_o (rec_rank)
  );

  repl_rank_tracker #(.NUM_WAYS(NUM_WAYS)) u_insertion (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (fill_evt),
    .way_i  (acc_way_i),
    .rank_o (ins_rank)
  );

  repl_lfsr #(.LFSR_W(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (lfsr_state)
  );

  repl_victim_select #(.NUM_WAYS(NUM_WAYS)) u_select (
    .valid_i    (valid_q),
    .rec_rank_i (rec_rank),
    .ins_rank_i (ins_rank),
    .rand_way_i (lfsr_state[WAY_W-1:0]),
    .policy_i   (policy_i),
    .victim_o   (victim_comb)
  );

  always_comb begin
    valid_d = valid_q;
    if (fill_evt) valid_d[acc_way_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       valid_q <= '0;
    else if (fill_evt) valid_q <= valid_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    victim_q <= '0;
    else if (req_i) victim_q <= victim_comb;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vvalid_q <= 1'b0;
    else         vvalid_q <= req_i;
  end

  assign victim_o       = victim_q;
  assign victim_valid_o = vvalid_q;
endmodule

// File: rtl/repl_policy_chk.sv
module repl_policy_chk #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned LFSR_W   = 8,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned RANK_W  = $clog2(NUM_WAYS)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       acc_valid_i,
  input logic                       acc_fill_i,
  input logic [WAY_W-1:0]           acc_way_i,
  input logic                       req_i,
  input logic [WAY_W-1:0]           victim_o,
  input logic                       victim_valid_o,
  input logic [NUM_WAYS-1:0]        valid_q,
  input logic [NUM_WAYS*RANK_W-1:0] rec_rank,
  input logic [NUM_WAYS*RANK_W-1:0] ins_rank,
  input logic [LFSR_W-1:0]          lfsr_state
);
  logic [NUM_WAYS-1:0] rec_hold [NUM_WAYS];
  logic [NUM_WAYS-1:0] ins_hold [NUM_WAYS];
  logic [WAY_W-1:0]    low_inv;

  always_comb begin
    for (int r = 0; r < NUM_WAYS; r++) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        rec_hold[r][w] = (rec_rank[w*RANK_W +: RANK_W] == RANK_W'(r));
        ins_hold[r][w] = (ins_rank[w*RANK_W +: RANK_W] == RANK_W'(r));
      end
    end
  end

  always_comb begin
    low_inv = '0;
    for (int w = NUM_WAYS-1; w >= 0; w--) if (!valid_q[w]) low_inv = WAY_W'(w);
  end

  generate
    for (genvar r = 0; r < NUM_WAYS; r++) begin : g_perm
      // R9
      rec_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(rec_hold[r]) == 1);
      // R9
      ins_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(ins_hold[r]) == 1);
    end
  endgenerate

  // R2
  req_response_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> victim_valid_o);

  // R2
  victim_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!victim_valid_o && $stable(victim_o)));

  // R3
  invalid_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !(&valid_q)) |=> victim_o == $past(low_inv));

  // R11
  fill_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_fill_i) |=> valid_q[$past(acc_way_i)]);

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_state != '0);
endmodule

bind repl_policy_unit repl_policy_chk #(.NUM_WAYS(NUM_WAYS), .LFSR_W(LFSR_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .acc_valid_i    (acc_valid_i),
  .acc_fill_i     (acc_fill_i),
  .acc_way_i      (acc_way_i),
  .req_i          (req_i),
  .victim_o       (victim_o),
  .victim_valid_o (victim_valid_o),
  .valid_q        (valid_q),
  .rec_rank       (rec_rank),
  .ins_rank       (ins_rank),
  .lfsr_state     (lfsr_state)
);

// File: tb/repl_policy_unit_tb.sv
module repl_policy_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  // vector: {op[1:0], way[1:0], pol[2:0], exp[1:0]}
  // op: 0 hit, 1 fill, 2 request, 3 request expecting invalid-first
  localparam int NVEC = 27;
  localparam logic [8:0] VEC [NVEC] = '{
    {2'd3, 2'd0, 3'd0, 2'd0},  // R3 all invalid
    {2'd1, 2'd0, 3'd0, 2'd0},  // fill 0
    {2'd3, 2'd0, 3'd0, 2'd1},  // R3 way 1 lowest invalid
    {2'd1, 2'd2, 3'd0, 2'd0},  // fill 2
    {2'd1, 2'd1, 3'd0, 2'd0},  // fill 1
    {2'd3, 2'd0, 3'd1, 2'd3},  // R3 under MRU
    {2'd1, 2'd3, 3'd0, 2'd0},  // fill 3 -> all valid
    {2'd2, 2'd0, 3'd0, 2'd0},  // R4
    {2'd2, 2'd0, 3'd1, 2'd3},  // R5
    {2'd2, 2'd0, 3'd2, 2'd0},  // R6
    {2'd2, 2'd0, 3'd3, 2'd3},  // R7
    {2'd0, 2'd0, 3'd0, 2'd0},  // hit 0
    {2'd2, 2'd0, 3'd0, 2'd2},  // R4 R9 recency aged
    {2'd2, 2'd0, 3'd1, 2'd0},  // R5
    {2'd2, 2'd0, 3'd2, 2'd0},  // R6 R9 hit left fill order
    {2'd2, 2'd0, 3'd3, 2'd3},  // R7 R12 history kept across switches
    {2'd0, 2'd2, 3'd0, 2'd0},  // hit 2
    {2'd2, 2'd0, 3'd0, 2'd1},  // R4
    {2'd2, 2'd0, 3'd1, 2'd2},  // R5
    {2'd2, 2'd0, 3'd2, 2'd0},  // R6
    {2'd1, 2'd1, 3'd0, 2'd0},  // refill 1
    {2'd2, 2'd0, 3'd0, 2'd3},  // R4
    {2'd2, 2'd0, 3'd1, 2'd1},  // R5
    {2'd2, 2'd0, 3'd2, 2'd0},  // R6
    {2'd2, 2'd0, 3'd3, 2'd1},  // R7 R9 fill moved fill order
    {2'd2, 2'd0, 3'd5, 2'd3},  // R10
    {2'd2, 2'd0, 3'd7, 2'd3}   // R10
  };

  logic       clk, rst_n;
  logic       acc_valid, acc_fill, req;
  logic [1:0] acc_way, victim;
  logic [2:0] policy;
  logic       victim_valid;
  logic [7:0] lfsr_m;
  int         n_chk, n_fail;
  bit         done;

  repl_policy_unit dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .acc_valid_i    (acc_valid),
    .acc_fill_i     (acc_fill),
    .acc_way_i      (acc_way),
    .req_i          (req),
    .policy_i       (policy),
    .victim_o       (victim),
    .victim_valid_o (victim_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // R8 model of the random source
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_m <= 8'hA5;
    else        lfsr_m <= {lfsr_m[6:0], lfsr_m[7] ^ lfsr_m[5] ^ lfsr_m[4] ^ lfsr_m[3]};
  end

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic fill, input logic [1:0] way);
    @(negedge clk);
    acc_valid = 1'b1; acc_fill = fill; acc_way = way;
    @(negedge clk);
    acc_valid = 1'b0; acc_fill = 1'b0;
  endtask

  task automatic request(input logic [2:0] pol, input string tag, input logic use_rand,
                         input logic [1:0] exp_in);
    logic [1:0] exp;
    @(negedge clk);
    req = 1'b1; policy = pol;
    exp = use_rand ? lfsr_m[1:0] : exp_in;
    @(negedge clk);
    req = 1'b0;
    check(tag, {2'b0, victim}, {2'b0, exp});
    check({tag, " valid"}, {3'b0, victim_valid}, 4'd1);
  endtask

  function automatic string tag_of(input logic [1:0] op, input logic [2:0] pol);
    if (op == 2'd3) return "R3";
    case (pol)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; acc_valid = 1'b0; acc_fill = 1'b0; acc_way = '0;
    req = 1'b0; policy = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 victim", {2'b0, victim}, 4'd0);
    check("R1 valid", {3'b0, victim_valid}, 4'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op, way, ex;
      logic [2:0] pol;
      {op, way, pol, ex} = VEC[i];
      if (op[1]) request(pol, tag_of(op, pol), 1'b0, ex);
      else       access(op[0], way);
    end

    // R2 no request: policy changes leave victim and flag alone
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      policy = 3'(k);
      check("R2 hold", {2'b0, victim}, 4'd3);
      check("R2 no pulse", {3'b0, victim_valid}, 4'd0);
    end

    // R8 random policy against model
    for (int k = 0; k < 10; k++) begin
      request(3'd4, "R8", 1'b1, 2'd0);
      repeat (k % 3) @(negedge clk);
    end

    // R1 mid-run reset, then R11 validity from fills
    do_reset();
    check("R1 victim after reset", {2'b0, victim}, 4'd0);
    request(3'd2, "R1 R3 all invalid", 1'b0, 2'd0);
    access(1'b0, 2'd0);                       // hit does not validate
    request(3'd0, "R11 hit no valid", 1'b0, 2'd0);
    access(1'b1, 2'd2);
    request(3'd0, "R11", 1'b0, 2'd0);
    access(1'b1, 2'd0);
    access(1'b1, 2'd1);
    request(3'd3, "R11 R3", 1'b0, 2'd3);
    access(1'b1, 2'd3);
    // fill order 2,0,1,3 ; R1 rank reset confirmed via R6/R7
    request(3'd2, "R6 after reset", 1'b0, 2'd2);
    request(3'd3, "R7 after reset", 1'b0, 2'd3);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule